// File: doc/BRIEF.md
# Cell and Temperature Limit Monitor

This block watches the stream of conversion results coming out of a battery-stack measurement front end. Each result carries a channel number, a flag saying whether it is a cell voltage or an auxiliary (thermistor) input, and a 15-bit code. In the cycle a result is presented, the block compares it against limits that software has programmed, and it sets a sticky flag when the value is outside them.

Cell limits are 8-bit values in coarse steps of 128 codes each. Temperature limits are 10-bit values in steps of 32 codes each. Each limit is widened by a fixed left shift before the compare. The thermistor voltage falls as temperature rises, so a code below the hot limit means too hot, and a code above the cold limit means too cold.

The flags stay set until software writes a 1 to the matching clear bit. A registered fault output is the OR of every flag whose category is enabled onto it.

Top module: `cell_limit_monitor`

## Requirements
- R1: A cell result on an enabled channel whose code is strictly greater than the overvoltage limit shifted left by 7 sets that channel's overvoltage flag at the clock edge that samples the result. A code equal to the shifted limit sets nothing.
- R2: A cell result on an enabled channel whose code is strictly less than the undervoltage limit shifted left by 7 sets that channel's undervoltage flag at the same edge. A code equal to the shifted limit sets nothing.
- R3: An auxiliary result whose code is strictly less than the hot limit shifted left by 5 sets that channel's overtemperature flag. An auxiliary result whose code is strictly greater than the cold limit shifted left by 5 sets its undertemperature flag. A code equal to either shifted limit sets nothing.
- R4: After reset the registers hold their defaults and the outputs are zero. The defaults are: overvoltage limit 215 (code 27520), undervoltage limit 128 (code 16384), hot limit 238 (code 7616), cold limit 782 (code 25024), cell enable 0x3F and fault enable 0xF. Every flag and the fault output are 0.
- R5: A write with wr_en high updates the addressed register at the clock edge, and the new value governs results from the next cycle on. The register addresses are:
  - 0: overvoltage limit, data bits [7:0]
  - 1: undervoltage limit, data bits [7:0]
  - 2: hot limit, data bits [9:0]
  - 3: cold limit, data bits [9:0]
  - 4: cell enable, bit n enables cell n
  - 5: fault enable, bit 0 overvoltage, bit 1 undervoltage, bit 2 overtemperature, bit 3 undertemperature
- R6: A result on a disabled cell channel never sets a flag. A result whose channel number is 6 or above for cells, or 7 or above for auxiliary inputs, changes no flag.
- R7: Flags are sticky. Writing to address 6 clears overvoltage flag n where data bit n is 1, and clears undervoltage flag n where data bit 8+n is 1. Writing to address 7 clears overtemperature flag n where data bit n is 1, and clears undertemperature flag n where data bit 8+n is 1. A flag being set in the same cycle as its clear stays set.
- R8: fault_out is high one cycle after any flag of an enabled category is high. It is low one cycle after no enabled category has a flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | A conversion result is presented this cycle |
| res_aux | input | 1 | 1: auxiliary/thermistor result, 0: cell result |
| res_chan | input | 4 | Channel number of the result |
| res_code | input | 15 | Conversion code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| ov_flags | output | 6 | Sticky cell overvoltage flags |
| uv_flags | output | 6 | Sticky cell undervoltage flags |
| ot_flags | output | 7 | Sticky overtemperature flags |
| ut_flags | output | 7 | Sticky undertemperature flags |
| fault_out | output | 1 | Registered OR of enabled flag categories |

## Verification
Each limit is approached with a code equal to its shifted value and then with one code past it. This tells a strict compare from an inclusive one, and a correct shift from an off-by-one shift. The same code pattern is also applied to a disabled cell, to out-of-range channel numbers and to the auxiliary path. These separate the enable and range gating from the compare itself, and show that the thermistor direction is inverted. Clears are tried alone and together with a new fault on the same flag. The fault enable is toggled while flags are held, which isolates the masking from the flag state.

// File: rtl/lim_pkg.sv
package lim_pkg;

    // Register addresses of the write port
    typedef enum logic [2:0] {
        A_OV_THR   = 3'd0,
        A_UV_THR   = 3'd1,
        A_OT_THR   = 3'd2,
        A_UT_THR   = 3'd3,
        A_CELL_EN  = 3'd4,
        A_FLT_EN   = 3'd5,
        A_CLR_CELL = 3'd6,
        A_CLR_AUX  = 3'd7
    } reg_addr_e;

    // Bit positions in the fault-enable register
    localparam int CAT_OV = 0;
    localparam int CAT_UV = 1;
    localparam int CAT_OT = 2;
    localparam int CAT_UT = 3;
    localparam int N_CAT  = 4;

endpackage

// File: rtl/lim_window.sv
// Scales an upper and a lower limit into the code domain and compares.
module lim_window #(
    parameter int THR_W  = 8,
    parameter int CODE_W = 15
) (
    input  logic [CODE_W-1:0] code,
    input  logic [THR_W-1:0]  thr_hi,
    input  logic [THR_W-1:0]  thr_lo,
    output logic              above,
    output logic              below
);
    localparam int SHIFT = CODE_W - THR_W;

    logic [CODE_W-1:0] hi_scaled;
    logic [CODE_W-1:0] lo_scaled;

    assign hi_scaled = {thr_hi, {SHIFT{1'b0}}};
    assign lo_scaled = {thr_lo, {SHIFT{1'b0}}};
    assign above     = code > hi_scaled;
    assign below     = code < lo_scaled;

endmodule

// File: rtl/lim_cfg.sv
// Limit, enable and mask registers plus clear strobe decode.
module lim_cfg
    import lim_pkg::*;
#(
    parameter int N_CELL     = 6,
    parameter int N_AUX      = 7,
    parameter int CELL_THR_W = 8,
    parameter int TEMP_THR_W = 10,
    parameter int DATA_W     = 16,
    parameter int OV_RST     = 215,
    parameter int UV_RST     = 128,
    parameter int OT_RST     = 238,
    parameter int UT_RST     = 782
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [CELL_THR_W-1:0] ov_thr,
    output logic [CELL_THR_W-1:0] uv_thr,
    output logic [TEMP_THR_W-1:0] ot_thr,
    output logic [TEMP_THR_W-1:0] ut_thr,
    output logic [N_CELL-1:0]     cell_en,
    output logic [N_CAT-1:0]      flt_en,
    output logic [N_CELL-1:0]     clr_ov,
    output logic [N_CELL-1:0]     clr_uv,
    output logic [N_AUX-1:0]      clr_ot,
    output logic [N_AUX-1:0]      clr_ut
);
    localparam int HALF = DATA_W / 2;

    typedef struct packed {
        logic [CELL_THR_W-1:0] ov;
        logic [CELL_THR_W-1:0] uv;
        logic [TEMP_THR_W-1:0] ot;
        logic [TEMP_THR_W-1:0] ut;
        logic [N_CELL-1:0]     cen;
        logic [N_CAT-1:0]      fen;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wr;

    assign unused_wr = ^wr_data;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                A_OV_THR:  cfg_d.ov  = wr_data[CELL_THR_W-1:0];
                A_UV_THR:  cfg_d.uv  = wr_data[CELL_THR_W-1:0];
                A_OT_THR:  cfg_d.ot  = wr_data[TEMP_THR_W-1:0];
                A_UT_THR:  cfg_d.ut  = wr_data[TEMP_THR_W-1:0];
                A_CELL_EN: cfg_d.cen = wr_data[N_CELL-1:0];
                A_FLT_EN:  cfg_d.fen = wr_data[N_CAT-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.ov  <= CELL_THR_W'(OV_RST);
            cfg_q.uv  <= CELL_THR_W'(UV_RST);
            cfg_q.ot  <= TEMP_THR_W'(OT_RST);
            cfg_q.ut  <= TEMP_THR_W'(UT_RST);
            cfg_q.cen <= '1;
            cfg_q.fen <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ov_thr  = cfg_q.ov;
    assign uv_thr  = cfg_q.uv;
    assign ot_thr  = cfg_q.ot;
    assign ut_thr  = cfg_q.ut;
    assign cell_en = cfg_q.cen;
    assign flt_en  = cfg_q.fen;

    assign clr_ov = (wr_en && wr_addr == A_CLR_CELL) ? wr_data[N_CELL-1:0]      : '0;
    assign clr_uv = (wr_en && wr_addr == A_CLR_CELL) ? wr_data[HALF+N_CELL-1:HALF] : '0;
    assign clr_ot = (wr_en && wr_addr == A_CLR_AUX)  ? wr_data[N_AUX-1:0]       : '0;
    assign clr_ut = (wr_en && wr_addr == A_CLR_AUX)  ? wr_data[HALF+N_AUX-1:HALF]  : '0;

    // R5: a limit write is visible in the register after the edge
    assert_ov_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_OV_THR) |=> ov_thr == $past(wr_data[CELL_THR_W-1:0]));
    assert_ot_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_OT_THR) |=> ot_thr == $past(wr_data[TEMP_THR_W-1:0]));

endmodule

// File: rtl/cell_limit_monitor.sv
module cell_limit_monitor
    import lim_pkg::*;
#(
    parameter int N_CELL     = 6,
    parameter int N_AUX      = 7,
    parameter int CODE_W     = 15,
    parameter int CHAN_W     = 4,
    parameter int DATA_W     = 16,
    parameter int CELL_THR_W = 8,
    parameter int TEMP_THR_W = 10,
    parameter int OV_RST     = 215,
    parameter int UV_RST     = 128,
    parameter int OT_RST     = 238,
    parameter int UT_RST     = 782
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic              res_aux,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic [CODE_W-1:0] res_code,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N_CELL-1:0] ov_flags,
    output logic [N_CELL-1:0] uv_flags,
    output logic [N_AUX-1:0]  ot_flags,
    output logic [N_AUX-1:0]  ut_flags,
    output logic              fault_out
);
    typedef struct packed {
        logic [N_CELL-1:0] ov;
        logic [N_CELL-1:0] uv;
        logic [N_AUX-1:0]  ot;
        logic [N_AUX-1:0]  ut;
        logic              fault;
    } st_t;

    logic [CELL_THR_W-1:0] ov_thr, uv_thr;
    logic [TEMP_THR_W-1:0] ot_thr, ut_thr;
    logic [N_CELL-1:0]     cell_en, clr_ov, clr_uv;
    logic [N_AUX-1:0]      clr_ot, clr_ut;
    logic [N_CAT-1:0]      flt_en;
    logic                  c_above, c_below, a_above, a_below;
    logic [N_CELL-1:0]     cell_sel;
    logic [N_AUX-1:0]      aux_sel;
    st_t                   st_d, st_q;

    lim_cfg #(
        .N_CELL(N_CELL), .N_AUX(N_AUX), .CELL_THR_W(CELL_THR_W),
        .TEMP_THR_W(TEMP_THR_W), .DATA_W(DATA_W), .OV_RST(OV_RST),
        .UV_RST(UV_RST), .OT_RST(OT_RST), .UT_RST(UT_RST)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ov_thr(ov_thr), .uv_thr(uv_thr),
        .ot_thr(ot_thr), .ut_thr(ut_thr), .cell_en(cell_en),
        .flt_en(flt_en), .clr_ov(clr_ov), .clr_uv(clr_uv),
        .clr_ot(clr_ot), .clr_ut(clr_ut)
    );

    // Cell path: upper limit is overvoltage, lower is undervoltage
    lim_window #(.THR_W(CELL_THR_W), .CODE_W(CODE_W)) i_cell_win (
        .code(res_code), .thr_hi(ov_thr), .thr_lo(uv_thr),
        .above(c_above), .below(c_below)
    );

    // Thermistor path: voltage falls with heat, so the cold limit is the
    // upper bound and the hot limit the lower bound
    lim_window #(.THR_W(TEMP_THR_W), .CODE_W(CODE_W)) i_aux_win (
        .code(res_code), .thr_hi(ut_thr), .thr_lo(ot_thr),
        .above(a_above), .below(a_below)
    );

    always_comb begin
        for (int i = 0; i < N_CELL; i++) begin
            cell_sel[i] = res_valid && !res_aux && cell_en[i] &&
                          (res_chan == CHAN_W'(i));
        end
        for (int i = 0; i < N_AUX; i++) begin
            aux_sel[i] = res_valid && res_aux && (res_chan == CHAN_W'(i));
        end

        st_d       = st_q;
        st_d.ov    = (st_q.ov & ~clr_ov) | (cell_sel & {N_CELL{c_above}});
        st_d.uv    = (st_q.uv & ~clr_uv) | (cell_sel & {N_CELL{c_below}});
        st_d.ot    = (st_q.ot & ~clr_ot) | (aux_sel & {N_AUX{a_below}});
        st_d.ut    = (st_q.ut & ~clr_ut) | (aux_sel & {N_AUX{a_above}});
        st_d.fault = ((|st_q.ov) && flt_en[CAT_OV]) ||
                     ((|st_q.uv) && flt_en[CAT_UV]) ||
                     ((|st_q.ot) && flt_en[CAT_OT]) ||
                     ((|st_q.ut) && flt_en[CAT_UT]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ov_flags  = st_q.ov;
    assign uv_flags  = st_q.uv;
    assign ot_flags  = st_q.ot;
    assign ut_flags  = st_q.ut;
    assign fault_out = st_q.fault;

    generate
        for (genvar g = 0; g < N_CELL; g++) begin : g_cell_chk
            // R6: a cell flag only rises from a result on that enabled channel
            assert_ov_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q.ov[g]) |-> $past(res_valid && !res_aux &&
                                            res_chan == CHAN_W'(g) && cell_en[g]));
            assert_uv_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q.uv[g]) |-> $past(res_valid && !res_aux &&
                                            res_chan == CHAN_W'(g) && cell_en[g]));
            // R7: a flag holds unless its clear bit is written
            assert_ov_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.ov[g] && !clr_ov[g]) |=> st_q.ov[g]);
        end
        for (genvar g = 0; g < N_AUX; g++) begin : g_aux_chk
            // R3: a temperature flag only rises from an auxiliary result
            assert_ot_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q.ot[g]) |-> $past(res_valid && res_aux &&
                                            res_chan == CHAN_W'(g)));
            assert_ut_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.ut[g] && !clr_ut[g]) |=> st_q.ut[g]);
        end
    endgenerate

    // R8: the fault pin follows enabled flags one cycle later
    assert_fault_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|st_q.ov) && flt_en[CAT_OV]) |=> fault_out);
    assert_fault_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ov == '0 && st_q.uv == '0 && st_q.ot == '0 && st_q.ut == '0) |=> !fault_out);

endmodule

// File: tb/test_cell_limit_monitor.sv
module test_cell_limit_monitor;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0, res_aux = 1'b0;
    logic [3:0]  res_chan = '0;
    logic [14:0] res_code = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  ov_flags, uv_flags;
    logic [6:0]  ot_flags, ut_flags;
    logic        fault_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    cell_limit_monitor i_cell_limit_monitor (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_aux(res_aux),
        .res_chan(res_chan), .res_code(res_code), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ov_flags(ov_flags),
        .uv_flags(uv_flags), .ot_flags(ot_flags), .ut_flags(ut_flags),
        .fault_out(fault_out)
    );

    typedef struct {
        logic [5:0] ov, uv;
        logic [6:0] ot, ut;
        logic       f;
        string      req;
    } exp_t;

    exp_t q[$];

    // Model state built from the requirements
    logic [5:0] m_ov = '0, m_uv = '0;
    logic [6:0] m_ot = '0, m_ut = '0;
    logic       m_f = 1'b0;
    int         m_ovt = 215, m_uvt = 128, m_ott = 238, m_utt = 782;
    logic [5:0] m_cen = 6'h3F;
    logic [3:0] m_fen = 4'hF;

    task automatic step(input string req, input bit v, input bit aux,
                        input int ch, input int code, input bit we,
                        input int addr, input logic [15:0] data);
        logic nf;
        @(negedge clk);
        res_valid = v; res_aux = aux; res_chan = 4'(ch); res_code = 15'(code);
        wr_en = we; wr_addr = 3'(addr); wr_data = data;
        nf = ((|m_ov) && m_fen[0]) || ((|m_uv) && m_fen[1]) ||
             ((|m_ot) && m_fen[2]) || ((|m_ut) && m_fen[3]);
        if (we && addr == 6) begin m_ov &= ~data[5:0]; m_uv &= ~data[13:8]; end
        if (we && addr == 7) begin m_ot &= ~data[6:0]; m_ut &= ~data[14:8]; end
        if (v && !aux && ch < 6 && m_cen[ch]) begin
            if (code > m_ovt * 128) m_ov[ch] = 1'b1;
            if (code < m_uvt * 128) m_uv[ch] = 1'b1;
        end
        if (v && aux && ch < 7) begin
            if (code < m_ott * 32) m_ot[ch] = 1'b1;
            if (code > m_utt * 32) m_ut[ch] = 1'b1;
        end
        if (we) begin
            case (addr)
                0: m_ovt = int'(data[7:0]);
                1: m_uvt = int'(data[7:0]);
                2: m_ott = int'(data[9:0]);
                3: m_utt = int'(data[9:0]);
                4: m_cen = data[5:0];
                5: m_fen = data[3:0];
                default: ;
            endcase
        end
        m_f = nf;
        q.push_back('{ov: m_ov, uv: m_uv, ot: m_ot, ut: m_ut, f: m_f, req: req});
    endtask

    task automatic res(input string req, input bit aux, input int ch, input int code);
        step(req, 1'b1, aux, ch, code, 1'b0, 0, 16'h0);
    endtask

    task automatic wr(input string req, input int addr, input logic [15:0] data);
        step(req, 1'b0, 1'b0, 0, 0, 1'b1, addr, data);
    endtask

    task automatic idle(input string req);
        step(req, 1'b0, 1'b0, 0, 0, 1'b0, 0, 16'h0);
    endtask

    // Monitor: one expected item per clock, compared after the edge
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (ov_flags !== e.ov || uv_flags !== e.uv || ot_flags !== e.ot ||
                ut_flags !== e.ut || fault_out !== e.f) begin
                errors++;
                $display("FAIL %s: got ov=%h uv=%h ot=%h ut=%h f=%b exp ov=%h uv=%h ot=%h ut=%h f=%b",
                         e.req, ov_flags, uv_flags, ot_flags, ut_flags, fault_out,
                         e.ov, e.uv, e.ot, e.ut, e.f);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R4: outputs after reset
        checks++;
        if ({ov_flags, uv_flags, ot_flags, ut_flags, fault_out} !== '0) begin
            errors++;
            $display("FAIL R4: got flags=%h exp 0",
                     {ov_flags, uv_flags, ot_flags, ut_flags, fault_out});
        end
        idle("R4");
        // R1: default overvoltage limit 215 -> 27520, strict compare
        res("R1", 1'b0, 0, 27520);
        res("R1", 1'b0, 0, 27521);
        idle("R8");
        // R2: default undervoltage limit 128 -> 16384
        res("R2", 1'b0, 1, 16384);
        res("R2", 1'b0, 1, 16383);
        // R3: hot limit 238 -> 7616, cold limit 782 -> 25024, inverted
        res("R3", 1'b1, 2, 7616);
        res("R3", 1'b1, 2, 7615);
        res("R3", 1'b1, 3, 25024);
        res("R3", 1'b1, 3, 25025);
        res("R3", 1'b1, 6, 12000);
        // R6: out-of-range channels and disabled cell
        res("R6", 1'b0, 6, 0);
        res("R6", 1'b1, 7, 0);
        res("R6", 1'b0, 15, 32767);
        wr("R6", 4, 16'h002F);
        res("R6", 1'b0, 4, 32767);
        res("R6", 1'b0, 4, 0);
        res("R6", 1'b0, 5, 32767);
        // R7: clears, alone and racing a new set
        wr("R7", 6, 16'h0001);
        step("R7", 1'b1, 1'b0, 1, 0, 1'b1, 6, 16'h0200);
        wr("R7", 6, 16'h0200);
        wr("R7", 7, 16'h0804);
        step("R7", 1'b1, 1'b1, 3, 32767, 1'b1, 7, 16'h0800);
        // R5: limit writes take effect for the next result
        step("R5", 1'b1, 1'b0, 2, 12801, 1'b1, 0, 16'd100);
        res("R5", 1'b0, 2, 12801);
        wr("R5", 2, 16'd1023);
        res("R5", 1'b1, 5, 32735);
        wr("R5", 1, 16'd0);
        res("R5", 1'b0, 3, 0);
        // R8: fault enable masking while flags are held
        wr("R8", 5, 16'h0000);
        idle("R8");
        idle("R8");
        wr("R8", 5, 16'h0004);
        idle("R8");
        wr("R7", 7, 16'h7F7F);
        idle("R8");
        idle("R8");
        wr("R8", 5, 16'h0001);
        idle("R8");
        idle("R8");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule